// File: doc/BRIEF.md
# Frequency Window Detector

This block decides whether a squared-up tone arriving from an analog comparator has a frequency inside a fixed pass band. It measures the tone against a local reference clock. The tone is first brought into the clock domain. It is then halved in frequency, which gives a waveform with exactly 50% duty cycle. While that half-rate waveform is high, the block counts reference clocks. That interval is one full period of the original tone, whatever the tone's own duty cycle.

On each falling edge of the half-rate waveform, the count is latched and compared against a window. The window limits come from the clock frequency parameter and the two band-edge frequency parameters. Two in-window measurements in a row confirm the tone. Once the tone is confirmed, the block raises a valid flag and passes the half-rate waveform itself to the wake output. A rejected measurement, or a long silence, withdraws the confirmation. The latched count is also brought out, so the measured period can be observed.

Top module: `fwin_detector`

## Requirements
- R1: While `rst` is high, `wake_out` is low. After a synchronous reset, `wake_valid` is low and `count_out` is zero.
- R2: `count_out` holds the tone period in reference clocks, exact to one clock. It is updated on every second rising edge of the tone, and it does not depend on the tone's duty cycle.
- R3: A measured period N is accepted when NMIN ≤ N ≤ NMAX, where NMIN = floor(FCLK_HZ/F_HI_HZ) and NMAX = ceil(FCLK_HZ/F_LO_HZ). With the defaults (1 MHz, 7 kHz and 62 kHz) the limits are 16 and 143.
- R4: The period counter saturates at NMAX+1 (144 by default). A tone slower than the window therefore reads NMAX+1 and is rejected.
- R5: `wake_valid` rises only after two consecutive accepted measurements. It stays low after a single accepted measurement.
- R6: A single rejected measurement drops `wake_valid` on the next clock.
- R7: If no measurement completes within 2·NMAX clocks (286 by default), `wake_valid` drops. Silences clearly shorter than this leave it set.
- R8: While `wake_valid` is high, `wake_out` follows the half-rate waveform: it is high for exactly one tone period and low for the next. `wake_out` is never high while `wake_valid` is low.
- R9: A tone faster or slower than the window never drives `wake_out` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | 1 | Asynchronous comparator output (the tone) |
| wake_out | output | 1 | Half-rate tone, gated by the confirmation |
| wake_valid | output | 1 | Tone confirmed in band |
| count_out | output | COUNT_W | Last latched period count |

## Verification
The hardest conditions to reach are the moments just before and just after a verdict changes. These are the single accepted measurement that must not yet confirm, and the lone out-of-band period arriving after a lock. The stimulus reaches them by stopping a tone after an exact number of periods, counted from reset. Because the halver's phase is then known, the bench knows which tone edge closes each measurement. The timeout is approached from both sides by holding the input quiet for a silence just under 2·NMAX and then for one beyond it. The window edges are hit with periods of exactly NMIN−1, NMIN, NMAX and NMAX+1 clocks.

// File: rtl/fwin_pkg.sv
package fwin_pkg;

    // Floor and ceiling integer division, used to turn band edges into counts.
    function automatic int unsigned div_floor(input int unsigned num, input int unsigned den);
        return num / den;
    endfunction

    function automatic int unsigned div_ceil(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    // Verdict produced by the period meter at the end of each measurement.
    typedef struct packed {
        logic done;     // one-cycle strobe: a measurement just closed
        logic in_win;   // measured count lies inside the pass window
    } verdict_t;

    // Confirmation progress of the qualifier.
    typedef enum logic [1:0] {
        QS_IDLE = 2'd0,   // no accepted measurement pending
        QS_ONE  = 2'd1,   // one accepted measurement seen
        QS_LOCK = 2'd2    // confirmed in band
    } qual_e;

endpackage

// File: rtl/fwin_sync_edge.sv
module fwin_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    // STAGES flops of synchronizer followed by one history flop for edge detection
    logic [STAGES:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[STAGES-1:0], async_in};
    end

    assign rise = shreg[STAGES-1] & ~shreg[STAGES];

    // R2: a rising edge is reported for one cycle only
    p_single_rise_r2: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/fwin_halver.sv
module fwin_halver (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    output logic div,
    output logic div_up,
    output logic div_dn
);
    always_ff @(posedge clk) begin
        if (rst)       div <= 1'b0;
        else if (rise) div <= ~div;
    end

    assign div_up = rise & ~div;
    assign div_dn = rise &  div;

    // R2: every tone rising edge flips the half-rate waveform
    p_toggle_r2: assert property (@(posedge clk) disable iff (rst)
        rise |=> (div != $past(div)));
    // R2: no change of the half-rate waveform without a tone edge
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(div));
endmodule

// File: rtl/fwin_period_meter.sv
module fwin_period_meter
    import fwin_pkg::*;
#(
    parameter int unsigned NMIN = 16,
    parameter int unsigned NMAX = 143,
    parameter int          CW   = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          div,
    input  logic          div_up,
    input  logic          div_dn,
    output logic [CW-1:0] count_q,
    output verdict_t      verdict
);
    localparam int unsigned CAP = NMAX + 1;

    logic [CW-1:0] run;
    logic [CW-1:0] nxt;
    logic          nxt_ok;

    // Saturating increment: a stalled input cannot wrap into the window
    always_comb begin
        nxt    = (run >= CW'(CAP)) ? CW'(CAP) : run + 1'b1;
        nxt_ok = (nxt >= CW'(NMIN)) && (nxt <= CW'(NMAX));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= '0;
            count_q <= '0;
            verdict <= '0;
        end else begin
            verdict.done <= 1'b0;
            if (div_up) begin
                run <= '0;
            end else if (div_dn) begin
                count_q        <= nxt;
                verdict.done   <= 1'b1;
                verdict.in_win <= nxt_ok;
            end else if (div) begin
                run <= nxt;
            end
        end
    end

    // R4: the latched count never exceeds the saturation value
    p_count_cap_r4: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(CAP));
    // R2: each falling edge of the half-rate waveform closes exactly one measurement
    p_done_after_fall_r2: assert property (@(posedge clk) disable iff (rst)
        div_dn |=> verdict.done);
    // R2: the latched count is stable between measurements
    p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !div_dn |=> $stable(count_q));
endmodule

// File: rtl/fwin_qualifier.sv
module fwin_qualifier
    import fwin_pkg::*;
#(
    parameter int unsigned TMO = 286,
    parameter int          TW  = 9
) (
    input  logic     clk,
    input  logic     rst,
    input  verdict_t verdict,
    output logic     valid
);
    qual_e         st;
    logic [TW-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= QS_IDLE;
            tmr <= '0;
        end else if (verdict.done) begin
            tmr <= '0;
            if (verdict.in_win) st <= (st == QS_IDLE) ? QS_ONE : QS_LOCK;
            else                st <= QS_IDLE;
        end else if (tmr == TW'(TMO)) begin
            st <= QS_IDLE;
        end else begin
            tmr <= tmr + 1'b1;
        end
    end

    assign valid = (st == QS_LOCK);

    // R5: confirmation only follows an accepted measurement
    p_rise_needs_pass_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> $past(verdict.done && verdict.in_win));
    // R6: a rejected measurement withdraws confirmation
    p_reject_drops_r6: assert property (@(posedge clk) disable iff (rst)
        (verdict.done && !verdict.in_win) |=> !valid);
    // R7: the silence timer never runs past its limit
    p_timer_bound_r7: assert property (@(posedge clk) disable iff (rst)
        tmr <= TW'(TMO));
endmodule

// File: rtl/fwin_detector.sv
module fwin_detector
    import fwin_pkg::*;
#(
    parameter int unsigned FCLK_HZ     = 1_000_000,
    parameter int unsigned F_LO_HZ     = 7_000,
    parameter int unsigned F_HI_HZ     = 62_000,
    parameter int          SYNC_STAGES = 2,
    parameter int          COUNT_W     = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sig_in,
    output logic               wake_out,
    output logic               wake_valid,
    output logic [COUNT_W-1:0] count_out
);
    localparam int unsigned NMIN = div_floor(FCLK_HZ, F_HI_HZ);
    localparam int unsigned NMAX = div_ceil(FCLK_HZ, F_LO_HZ);
    localparam int unsigned TMO  = 2 * NMAX;
    localparam int          TW   = $clog2(TMO + 1);

    logic     rise;
    logic     div;
    logic     div_up;
    logic     div_dn;
    verdict_t verdict;

    initial begin
        a_count_fits_r4: assert ((NMAX + 1) < (32'd1 << COUNT_W))
            else $error("COUNT_W too narrow for NMAX+1");
    end

    fwin_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (sig_in),
        .rise     (rise)
    );

    fwin_halver u_half (
        .clk    (clk),
        .rst    (rst),
        .rise   (rise),
        .div    (div),
        .div_up (div_up),
        .div_dn (div_dn)
    );

    fwin_period_meter #(.NMIN(NMIN), .NMAX(NMAX), .CW(COUNT_W)) u_meter (
        .clk     (clk),
        .rst     (rst),
        .div     (div),
        .div_up  (div_up),
        .div_dn  (div_dn),
        .count_q (count_out),
        .verdict (verdict)
    );

    fwin_qualifier #(.TMO(TMO), .TW(TW)) u_qual (
        .clk     (clk),
        .rst     (rst),
        .verdict (verdict),
        .valid   (wake_valid)
    );

    assign wake_out = ~rst & div & wake_valid;

    // R8: the wake output is never active without confirmation
    p_wake_gated_r8: assert property (@(posedge clk) disable iff (rst)
        wake_out |-> wake_valid);
    // R1: reset forces the wake output low
    p_reset_low_r1: assert property (@(posedge clk)
        rst |-> !wake_out);
endmodule

// File: tb/test_fwin_detector.sv
`timescale 1ns/1ps
module test_fwin_detector;
    localparam int CW   = 12;
    localparam int NMIN = 16;
    localparam int NMAX = 143;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sig_in = 1'b0;
    logic          wake_out;
    logic          wake_valid;
    logic [CW-1:0] count_out;

    int checks = 0;
    int errors = 0;

    // wake_out monitor, sampled between edges
    int  hi_run   = 0;
    int  last_run = 0;
    int  hi_total = 0;
    int  rises    = 0;
    logic prev_w  = 1'b0;

    always #2.5 clk = ~clk;

    fwin_detector i_fwin_detector (
        .clk        (clk),
        .rst        (rst),
        .sig_in     (sig_in),
        .wake_out   (wake_out),
        .wake_valid (wake_valid),
        .count_out  (count_out)
    );

    always begin
        @(posedge clk);
        #1.25;
        if (wake_out) begin
            hi_run++;
            hi_total++;
            if (!prev_w) rises++;
        end else begin
            if (hi_run != 0) last_run = hi_run;
            hi_run = 0;
        end
        prev_w = wake_out;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst    = 1'b1;
        sig_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic tone(input int h, input int l, input int n);
        for (int i = 0; i < n; i++) begin
            sig_in = 1'b1;
            repeat (h) @(negedge clk);
            sig_in = 1'b0;
            repeat (l) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk(wake_valid == 1'b0, "R1 valid", wake_valid, 0);
        chk(wake_out == 1'b0, "R1 wake_out", wake_out, 0);
        chk(count_out == '0, "R1 count", count_out, 0);
    endtask

    task automatic t_nominal();
        int r0;
        do_reset();
        tone(35, 35, 3);
        chk(wake_valid == 1'b0, "R5 one measurement only", wake_valid, 0);
        chk(count_out == 70, "R2 period 70", count_out, 70);
        tone(35, 35, 1);
        chk(wake_valid == 1'b1, "R5 two measurements", wake_valid, 1);
        r0 = rises;
        tone(35, 35, 4);
        chk(last_run == 70, "R8 high run one period", last_run, 70);
        chk(rises - r0 == 2, "R8 half-rate rises", rises - r0, 2);
    endtask

    task automatic t_duty();
        do_reset();
        tone(5, 45, 4);
        chk(count_out == 50, "R2 skewed duty count", count_out, 50);
        chk(wake_valid == 1'b1, "R2 skewed duty valid", wake_valid, 1);
    endtask

    task automatic t_edge(input int p, input bit exp_ok);
        do_reset();
        tone(p / 2, p - p / 2, 4);
        chk(count_out == p, "R3 edge count", count_out, p);
        chk(wake_valid == exp_ok, "R3 window edge", wake_valid, int'(exp_ok));
    endtask

    task automatic t_saturate();
        do_reset();
        tone(150, 150, 4);
        chk(count_out == NMAX + 1, "R4 saturation", count_out, NMAX + 1);
        chk(wake_valid == 1'b0, "R4 slow rejected", wake_valid, 0);
    endtask

    task automatic t_reject();
        do_reset();
        tone(25, 25, 6);
        chk(wake_valid == 1'b1, "R6 locked before", wake_valid, 1);
        tone(5, 5, 1);
        chk(wake_valid == 1'b1, "R6 no measurement yet", wake_valid, 1);
        tone(5, 5, 1);
        chk(wake_valid == 1'b0, "R6 one rejection drops", wake_valid, 0);
        chk(count_out == 10, "R6 fast count", count_out, 10);
    endtask

    task automatic t_timeout();
        do_reset();
        tone(25, 25, 6);
        repeat (200) @(negedge clk);
        chk(wake_valid == 1'b1, "R7 short silence kept", wake_valid, 1);
        repeat (100) @(negedge clk);
        chk(wake_valid == 1'b0, "R7 timeout drops", wake_valid, 0);
        chk(wake_out == 1'b0, "R8 low when invalid", wake_out, 0);
    endtask

    task automatic t_block();
        int h0;
        do_reset();
        h0 = hi_total;
        tone(3, 3, 30);
        tone(200, 200, 3);
        chk(hi_total == h0, "R9 out-of-band never wakes", hi_total - h0, 0);
        chk(wake_valid == 1'b0, "R9 valid stays low", wake_valid, 0);
    endtask

    task automatic t_reset_mid();
        do_reset();
        tone(25, 25, 5);
        chk(wake_out == 1'b1, "R8 wake follows half-rate", wake_out, 1);
        rst = 1'b1;
        #0.5;
        chk(wake_out == 1'b0, "R1 wake low in reset", wake_out, 0);
        @(negedge clk);
        chk(wake_valid == 1'b0, "R1 valid cleared", wake_valid, 0);
        rst = 1'b0;
    endtask

    initial begin
        t_reset();
        t_nominal();
        t_duty();
        t_edge(NMIN, 1'b1);
        t_edge(NMIN - 1, 1'b0);
        t_edge(NMAX, 1'b1);
        t_edge(NMAX + 1, 1'b0);
        t_saturate();
        t_reject();
        t_timeout();
        t_block();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule